// File: doc/BRIEF.md
# Video Capture Control and Status Register

This block is the single 32-bit control and status word of a video capture unit. Software writes it through a plain write port and reads it back combinationally. The capture datapath drives it with single-cycle event pulses: field start (with the new field number), vsync, hsync, vertical start, DMA end, and error (with a 4-bit error code).

One word holds four kinds of bits, and each kind follows its own write rule. Control bits are plain read/write. Status flags are sticky and cleared by writing 1. The error code is loaded by hardware. The field number is owned by hardware and cannot be written. A soft-reset bit stays set until software writes it back to 0, and while it is set the rest of the word is held at zero.

A registered interrupt request is raised when any status flag is set together with its enable. Error-correction failures have an extra enable path of their own. Control bits are also driven out as level outputs for the capture datapath.

Top module: `vcap_csr`

## Requirements
- R1: Writing 1 to bit 0 sets bit 0 and clears every other bit, including the status flags, the error code and the field bit. It also drives `capture_rst` high and `irq` low. While bit 0 is set, events and the other write data are ignored. A write with bit 0 = 0 releases the reset and loads the control bits from that same write.
- R2: The control bits are read/write and each drives an output. The interrupt enables are bits 14:8. Bit 27 enables DMA (`dma_en`), bit 29 enables dithering (`dither_en`), bit 30 enables rounding (`round_en`), and bit 31 selects 32-bit RGBa output (`rgba_mode`; 0 selects 16-bit 565).
- R3: An event pulse sets its sticky status flag, which stays set until it is cleared. The flags are: field bit 16, vsync bit 17, hsync bit 18, vertical start bit 19, DMA end bit 20, error bit 21.
- R4: Writing 1 to a status bit (mask 0x003F0000) clears that bit. Writing 0 to a status bit leaves it unchanged.
- R5: When an event and a write-1-to-clear hit the same status bit in the same cycle, the event wins and the bit is set.
- R6: An error pulse loads `err_code` into bits 7:4. Codes 0xA and 0xB denote single-bit and multi-bit ECC failures. The code is cleared whenever the error flag (bit 21) is cleared. Clearing any other status bit leaves the code unchanged.
- R7: A field pulse loads `field_num` into bit 28. Writes never change bit 28.
- R8: `irq` is registered. It goes high one cycle after some status flag is set together with its enable: bits 16..21 pair with enables 8..13. It falls one cycle after the last such pair goes away.
- R9: The error flag also raises `irq` when bit 14 is set and the error code is 0xA or 0xB, even if bit 13 is clear. Other codes do not raise `irq` through bit 14.
- R10: Bits 3:1, 15 and 26:22 always read 0. Write data on those bits and on bits 7:4 is ignored.
- R11: After `rst_n` is asserted low, the word reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| ev_field | input | 1 | Field start pulse |
| field_num | input | 1 | Number of the starting field |
| ev_vsync | input | 1 | Vertical sync pulse |
| ev_hsync | input | 1 | Horizontal sync pulse |
| ev_vstart | input | 1 | Vertical active start pulse |
| ev_dma_end | input | 1 | DMA completion pulse |
| ev_error | input | 1 | Error pulse |
| err_code | input | 4 | Error code qualified by ev_error |
| capture_rst | output | 1 | Soft reset to the capture datapath |
| dma_en | output | 1 | DMA transfer enable |
| dither_en | output | 1 | Dither enable |
| round_en | output | 1 | Rounding enable |
| rgba_mode | output | 1 | 32-bit output select |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions check several rules on every cycle:
- the word collapses to the reset value after a soft-reset write;
- an event sets its flag, and an event beats a same-cycle clear;
- a write-1 clears a flag when no event hits it;
- the field bit holds when there is no field pulse;
- a non-zero error code never appears without the error flag;
- `irq` follows an enabled pending flag one cycle later.

Only the directed scenarios can show the rest:
- that writes of 0 leave flags untouched;
- that the error code survives clears of other flags;
- which error codes the ECC enable selects;
- that reserved bits stay zero;
- that the control bits reach their outputs;
- that a write releasing the soft reset also loads the control bits.

// File: rtl/vcap_csr.sv
module vcap_csr #(
  parameter int NSTAT = 6,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              ev_field,
  input  logic              field_num,
  input  logic              ev_vsync,
  input  logic              ev_hsync,
  input  logic              ev_vstart,
  input  logic              ev_dma_end,
  input  logic              ev_error,
  input  logic [CODE_W-1:0] err_code,
  output logic              capture_rst,
  output logic              dma_en,
  output logic              dither_en,
  output logic              round_en,
  output logic              rgba_mode,
  output logic              irq
);

  localparam int CODE_LSB = 4;
  localparam int EN_LSB   = 8;
  localparam int NEN      = NSTAT + 1;
  localparam int ST_LSB   = 16;
  localparam int ERR_IDX  = NSTAT - 1;
  localparam int B_DMA    = 27;
  localparam int B_FLD    = 28;
  localparam int B_DITH   = 29;
  localparam int B_RND    = 30;
  localparam int B_M32    = 31;
  localparam logic [CODE_W-1:0] ECC1 = CODE_W'(4'hA);
  localparam logic [CODE_W-1:0] ECC2 = CODE_W'(4'hB);

  logic              srst_q;
  logic [CODE_W-1:0] code_q;
  logic [NEN-1:0]    en_q;
  logic [NSTAT-1:0]  stat_q;
  logic              dma_q, fld_q, dith_q, rnd_q, m32_q, irq_q;

  logic [NSTAT-1:0]  evt, clr, stat_nxt;
  logic              srst_wr, ecc_code, irq_nxt;

  assign evt      = {ev_error, ev_dma_end, ev_vstart, ev_hsync, ev_vsync, ev_field};
  assign srst_wr  = wr_en & wr_data[0];
  assign clr      = wr_en ? wr_data[ST_LSB +: NSTAT] : '0;
  assign stat_nxt = (stat_q & ~clr) | evt;
  assign ecc_code = (code_q == ECC1) || (code_q == ECC2);
  assign irq_nxt  = !srst_q && ((|(stat_q & en_q[NSTAT-1:0])) ||
                                (stat_q[ERR_IDX] && en_q[NEN-1] && ecc_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      code_q <= '0;
      en_q   <= '0;
      stat_q <= '0;
      dma_q  <= 1'b0;
      fld_q  <= 1'b0;
      dith_q <= 1'b0;
      rnd_q  <= 1'b0;
      m32_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (srst_wr) begin
      srst_q <= 1'b1;
      code_q <= '0;
      en_q   <= '0;
      stat_q <= '0;
      dma_q  <= 1'b0;
      fld_q  <= 1'b0;
      dith_q <= 1'b0;
      rnd_q  <= 1'b0;
      m32_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_nxt;
      if (wr_en) begin
        srst_q <= 1'b0;
        en_q   <= wr_data[EN_LSB +: NEN];
        dma_q  <= wr_data[B_DMA];
        dith_q <= wr_data[B_DITH];
        rnd_q  <= wr_data[B_RND];
        m32_q  <= wr_data[B_M32];
      end
      if (!srst_q) begin
        stat_q <= stat_nxt;
        if (ev_error)
          code_q <= err_code;
        else if (clr[ERR_IDX])
          code_q <= '0;
        if (ev_field)
          fld_q <= field_num;
      end
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[0]                   = srst_q;
    rd_data[CODE_LSB +: CODE_W]  = code_q;
    rd_data[EN_LSB +: NEN]       = en_q;
    rd_data[ST_LSB +: NSTAT]     = stat_q;
    rd_data[B_DMA]               = dma_q;
    rd_data[B_FLD]               = fld_q;
    rd_data[B_DITH]              = dith_q;
    rd_data[B_RND]               = rnd_q;
    rd_data[B_M32]               = m32_q;
  end

  assign capture_rst = srst_q;
  assign dma_en      = dma_q;
  assign dither_en   = dith_q;
  assign round_en    = rnd_q;
  assign rgba_mode   = m32_q;
  assign irq         = irq_q;

  p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> (rd_data == 32'h1 && !irq));

  p_ev_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_q && !srst_wr && ev_vsync) |=> rd_data[17]);

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_q && wr_en && !wr_data[0] && wr_data[18] && !ev_hsync) |=> !rd_data[18]);

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_q && wr_en && !wr_data[0] && wr_data[20] && ev_dma_end) |=> rd_data[20]);

  p_code_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:4] != 4'h0) |-> rd_data[21]);

  p_field_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_field && !srst_wr) |=> $stable(rd_data[B_FLD]));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[20] && rd_data[12] && !rd_data[0] && !srst_wr) |=> irq);

endmodule

// File: tb/vcap_csr_bench.sv
module vcap_csr_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  ev = '0;
  logic        field_num = 1'b0;
  logic [3:0]  err_code = '0;
  logic        capture_rst, dma_en, dither_en, round_en, rgba_mode, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcap_csr u_vcap_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_field(ev[0]), .field_num(field_num), .ev_vsync(ev[1]), .ev_hsync(ev[2]),
    .ev_vstart(ev[3]), .ev_dma_end(ev[4]), .ev_error(ev[5]), .err_code(err_code),
    .capture_rst(capture_rst), .dma_en(dma_en), .dither_en(dither_en),
    .round_en(round_en), .rgba_mode(rgba_mode), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [5:0] e, input logic fnum, input logic [3:0] code);
    ev = e; field_num = fnum; err_code = code;
    tick();
    ev = '0; field_num = 1'b0; err_code = '0;
  endtask

  task automatic t_reset();
    check("R11 word", rd_data, 32'h0);
    check("R11 outputs", {26'h0, capture_rst, dma_en, dither_en, round_en, rgba_mode, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(32'hE800_7F00);
    check("R2 readback", rd_data, 32'hE800_7F00);
    check("R2 outputs", {27'h0, dma_en, dither_en, round_en, rgba_mode, capture_rst}, 32'h1E);
    wr(32'h0800_0000);
    check("R2 dma only", {27'h0, dma_en, dither_en, round_en, rgba_mode, capture_rst}, 32'h10);
    wr(32'h0);
    check("R2 cleared", rd_data, 32'h0);
  endtask

  task automatic t_reserved();
    wr(32'h07C0_80FE);
    check("R10 reserved and code ignored", rd_data, 32'h0);
  endtask

  task automatic t_events();
    pulse(6'h01, 1'b0, 4'h0); check("R3 field", rd_data, 32'h0001_0000);
    pulse(6'h02, 1'b0, 4'h0); check("R3 vsync", rd_data, 32'h0003_0000);
    pulse(6'h04, 1'b0, 4'h0); check("R3 hsync", rd_data, 32'h0007_0000);
    pulse(6'h08, 1'b0, 4'h0); check("R3 vstart", rd_data, 32'h000F_0000);
    pulse(6'h10, 1'b0, 4'h0); check("R3 dma end", rd_data, 32'h001F_0000);
    pulse(6'h20, 1'b0, 4'h0); check("R3 error", rd_data, 32'h003F_0000);
    repeat (3) tick();
    check("R3 sticky", rd_data, 32'h003F_0000);
    wr(32'h003F_0000);
    check("R4 clear all", rd_data, 32'h0);
  endtask

  task automatic t_w1c();
    pulse(6'h3F, 1'b0, 4'h0);
    wr(32'h0005_0000);
    check("R4 partial clear", rd_data, 32'h003A_0000);
    wr(32'h0);
    check("R4 zero keeps", rd_data, 32'h003A_0000);
    wr(32'h003F_0000);
    check("R4 clear rest", rd_data, 32'h0);
  endtask

  task automatic t_collision();
    ev = 6'h02; wr_en = 1'b1; wr_data = 32'h0002_0000;
    tick();
    ev = '0; wr_en = 1'b0; wr_data = '0;
    check("R5 event beats clear", rd_data, 32'h0002_0000);
    wr(32'h0002_0000);
    check("R5 later clear", rd_data, 32'h0);
  endtask

  task automatic t_errcode();
    pulse(6'h20, 1'b0, 4'h5);
    check("R6 code load", rd_data, 32'h0020_0050);
    pulse(6'h30, 1'b0, 4'h8);
    check("R6 code replace", rd_data, 32'h0030_0080);
    wr(32'h0010_0000);
    check("R6 other clear keeps code", rd_data, 32'h0020_0080);
    wr(32'h0020_0000);
    check("R6 code cleared with flag", rd_data, 32'h0);
  endtask

  task automatic t_field();
    pulse(6'h01, 1'b1, 4'h0);
    check("R7 field one", rd_data, 32'h1001_0000);
    wr(32'h0001_0000);
    check("R7 write keeps field", rd_data, 32'h1000_0000);
    pulse(6'h01, 1'b0, 4'h0);
    check("R7 field zero", rd_data, 32'h0001_0000);
    wr(32'h003F_0000);
  endtask

  task automatic t_irq();
    wr(32'h0000_0200);
    pulse(6'h04, 1'b0, 4'h0);
    tick();
    check("R8 disabled flag no irq", {31'h0, irq}, 32'h0);
    pulse(6'h02, 1'b0, 4'h0);
    check("R8 irq registered", {31'h0, irq}, 32'h0);
    tick();
    check("R8 irq raised", {31'h0, irq}, 32'h1);
    wr(32'h0006_0200);
    check("R8 irq still from old state", {31'h0, irq}, 32'h1);
    tick();
    check("R8 irq falls", {31'h0, irq}, 32'h0);
    wr(32'h0);
  endtask

  task automatic t_ecc();
    wr(32'h0000_4000);
    pulse(6'h20, 1'b0, 4'h4);
    tick();
    check("R9 non ecc code", {31'h0, irq}, 32'h0);
    wr(32'h0020_4000);
    pulse(6'h20, 1'b0, 4'hB);
    tick();
    check("R9 ecc code irq", {31'h0, irq}, 32'h1);
    wr(32'h0020_4000);
    tick();
    check("R9 ecc cleared", {31'h0, irq}, 32'h0);
    wr(32'h0);
  endtask

  task automatic t_softreset();
    wr(32'hE800_7F00);
    pulse(6'h03, 1'b1, 4'h0);
    tick();
    check("R1 setup irq", {31'h0, irq}, 32'h1);
    wr(32'h1);
    check("R1 word collapses", rd_data, 32'h1);
    check("R1 outputs", {26'h0, capture_rst, dma_en, dither_en, round_en, rgba_mode, irq}, 32'h20);
    pulse(6'h3F, 1'b1, 4'h9);
    check("R1 events ignored", rd_data, 32'h1);
    wr(32'h0000_7F01);
    check("R1 writes ignored", rd_data, 32'h1);
    wr(32'h2000_0000);
    check("R1 release loads", rd_data, 32'h2000_0000);
    check("R1 release outputs", {26'h0, capture_rst, dma_en, dither_en, round_en, rgba_mode, irq}, 32'h08);
    wr(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ctrl();
    t_reserved();
    t_events();
    t_w1c();
    t_collision();
    t_errcode();
    t_field();
    t_irq();
    t_ecc();
    t_softreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule